// File: doc/BRIEF.md
# Inter-Processor Mailbox and Interrupt Unit

This block sits between the peripheral buses of two processors, called side A and side B. Each side has its own small register-mapped slave port. Through that port a side loads an outgoing word and then issues a send command. The send command copies the word into the peer's read-only inbox and raises an interrupt toward the peer. The send command chooses the kind of interrupt: a maskable request, which is a level held while a pending flag is set, or a non-maskable request, which is a single-cycle pulse. The receiver reads the inbox and then writes an acknowledge bit. If a send arrives while the receiver still holds an unacknowledged word, a sticky overrun flag is set and the stored word is kept.

The unit also has two poll registers that exchange data without any interrupt. Each side writes only its own poll register and can read both. Because of this, the two ports never contend, even when both write in the same cycle.

Each direction of travel is handled by its own channel state machine with two states. CH_EMPTY means no word is pending. CH_FULL means a word is waiting for acknowledge. The transitions are:

- CH_EMPTY to CH_FULL: a send is accepted.
- CH_FULL to CH_EMPTY: the receiver acknowledges and no send arrives in the same cycle.
- CH_FULL to CH_FULL with a new word: acknowledge and send arrive in the same cycle.
- CH_FULL to CH_FULL with overrun: a send arrives without an acknowledge.

A bus write is taken at the rising clock edge on which select and write are both high. Its effects are visible right after that edge. Read data is combinational from the address.

Register map (3-bit address, the same on both sides):

| Address | Access | Meaning |
|---|---|---|
| 0 | read/write | outgoing word |
| 1 | write only, reads 0 | send command: bit 0 requests a maskable send, bit 1 requests a non-maskable send |
| 2 | read only | inbox word |
| 3 | read/write | control and status, see below |
| 4 | read/write | this side's poll register |
| 5 | read only | the peer's poll register |
| 6, 7 | | read 0 |

Control and status register (address 3):
- On read: bit 0 is pending, bit 1 is overrun, bit 2 is mask enable.
- On write: bit 0 = 1 acknowledges, bit 1 = 1 clears overrun, and bit 2 is stored as the mask enable.

Top module: `icc_mailbox`

## Requirements
- R1: After reset, every register reads 0 on both sides. Every irq and nmi output is low.
- R2: A write to address 1 with bit 0 or bit 1 set, while the peer channel is CH_EMPTY, copies the sender's outgoing word into the peer inbox (address 2) and sets the peer pending bit (address 3, bit 0). Both are visible right after the write edge.
- R3: A side's irq output is high exactly when its pending bit and its mask enable (address 3, bit 2) are both 1.
- R4: An accepted send with bit 1 set drives the peer nmi high for exactly the one cycle after the write edge, whatever the mask enable. It also sets pending.
- R5: Pending stays set until the receiver writes address 3 with bit 0 = 1. That write clears it, unless a send is accepted in the same cycle.
- R6: A send while the peer is pending, with no acknowledge in the same cycle, sets the peer overrun bit (address 3, bit 1). It leaves the peer inbox unchanged and produces no nmi pulse.
- R7: Overrun stays set until the receiver writes address 3 with bit 1 = 1.
- R8: An acknowledge and a send in the same cycle accept the new word, keep pending set, and do not set overrun.
- R9: Each side writes its own poll register at address 4 and reads the peer's at address 5. Writes to address 5 and to address 2 have no effect. Simultaneous writes from both sides land independently.
- R10: A send command with bits 1:0 equal to 0 changes nothing.
- R11: The two directions are independent: traffic from A to B never alters the state of B to A, and the reverse holds too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| a_sel | input | 1 | side A access select |
| a_wr | input | 1 | side A write strobe |
| a_addr | input | 3 | side A register address |
| a_wdata | input | DATA_W | side A write data |
| a_rdata | output | DATA_W | side A read data |
| a_irq | output | 1 | maskable request toward side A |
| a_nmi | output | 1 | non-maskable pulse toward side A |
| b_sel | input | 1 | side B access select |
| b_wr | input | 1 | side B write strobe |
| b_addr | input | 3 | side B register address |
| b_wdata | input | DATA_W | side B write data |
| b_rdata | output | DATA_W | side B read data |
| b_irq | output | 1 | maskable request toward side B |
| b_nmi | output | 1 | non-maskable pulse toward side B |

## Verification
A channel stuck in the wrong state shows up right after the next write edge, in three ways. The pending bit reads wrongly at address 3. The irq level disagrees with pending and mask. Or an nmi pulse is missing or extra in the single cycle after a send. A corrupted inbox or poll register shows on the very next read of that address. A mishandled overrun shows as a changed inbox word or a wrong bit 1, in the cycle after the offending send. The bench reads every register of both sides after each cycle of stimulus, so any divergence is seen within one cycle of its cause.

// File: rtl/icc_mbx_pkg.sv
package icc_mbx_pkg;

    localparam int REG_AW = 3;

    localparam int SEND_IRQ_BIT = 0;
    localparam int SEND_NMI_BIT = 1;
    localparam int CTRL_ACK_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_MASK_BIT = 2;

    typedef enum logic [REG_AW-1:0] {
        RS_OUTBOX   = 3'd0,
        RS_SEND     = 3'd1,
        RS_INBOX    = 3'd2,
        RS_CTRL     = 3'd3,
        RS_MYPOLL   = 3'd4,
        RS_PEERPOLL = 3'd5,
        RS_RSV6     = 3'd6,
        RS_RSV7     = 3'd7
    } reg_sel_e;

    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_FULL  = 1'b1
    } chan_state_e;

endpackage

// File: rtl/icc_mbx_channel.sv
module icc_mbx_channel
    import icc_mbx_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_irq,
    input  logic              send_nmi,
    input  logic [DATA_W-1:0] send_word,
    input  logic              rx_ack,
    input  logic              rx_clr_ovf,
    input  logic              rx_mask_en,
    output logic [DATA_W-1:0] inbox,
    output logic              pending,
    output logic              overrun,
    output logic              irq,
    output logic              nmi
);

    chan_state_e state_q, state_d;
    logic        send;
    logic        accept;
    logic        nmi_q;

    assign send   = send_irq || send_nmi;
    assign accept = send && ((state_q == CH_EMPTY) || rx_ack);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_EMPTY: if (send) state_d = CH_FULL;
            CH_FULL:  if (rx_ack && !send) state_d = CH_EMPTY;
            default:  state_d = CH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inbox   <= '0;
            nmi_q   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (accept) inbox <= send_word;
            nmi_q <= accept && send_nmi;
            if (send && !accept)  overrun <= 1'b1;
            else if (rx_clr_ovf)  overrun <= 1'b0;
        end
    end

    always_comb begin
        pending = (state_q == CH_FULL);
        irq     = pending && rx_mask_en;
        nmi     = nmi_q;
    end

    // R2: an accepted send from the empty state latches the word
    a_r2_send_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EMPTY && send) |=> (pending && inbox == $past(send_word)));
    // R4: a pulse only follows an accepted send, so pending is set with it
    a_r4_nmi_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> pending);
    // R5
    a_r5_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FULL && rx_ack && !send) |=> !pending);
    // R6
    a_r6_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FULL && send && !rx_ack) |=> (overrun && $stable(inbox) && !nmi));
    // R7
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rx_clr_ovf) |=> overrun);
    // R8
    a_r8_ack_and_send: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FULL && send && rx_ack && !overrun && !rx_clr_ovf) |=> (pending && !overrun));

endmodule

// File: rtl/icc_mbx_port.sv
module icc_mbx_port
    import icc_mbx_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] inbox,
    input  logic              pending,
    input  logic              overrun,
    input  logic [DATA_W-1:0] peer_poll,
    output logic [DATA_W-1:0] out_word,
    output logic [DATA_W-1:0] my_poll,
    output logic              mask_en,
    output logic              send_irq,
    output logic              send_nmi,
    output logic              ack,
    output logic              clr_ovf
);

    localparam int STAT_W = 3;

    logic     wr_en;
    reg_sel_e reg_sel;

    assign wr_en   = sel && wr;
    assign reg_sel = reg_sel_e'(addr);

    always_comb begin
        send_irq = wr_en && (reg_sel == RS_SEND) && wdata[SEND_IRQ_BIT];
        send_nmi = wr_en && (reg_sel == RS_SEND) && wdata[SEND_NMI_BIT];
        ack      = wr_en && (reg_sel == RS_CTRL) && wdata[CTRL_ACK_BIT];
        clr_ovf  = wr_en && (reg_sel == RS_CTRL) && wdata[CTRL_CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            my_poll  <= '0;
            mask_en  <= 1'b0;
        end else if (wr_en) begin
            if (reg_sel == RS_OUTBOX) out_word <= wdata;
            if (reg_sel == RS_MYPOLL) my_poll  <= wdata;
            if (reg_sel == RS_CTRL)   mask_en  <= wdata[CTRL_MASK_BIT];
        end
    end

    always_comb begin
        unique case (reg_sel)
            RS_OUTBOX:   rdata = out_word;
            RS_INBOX:    rdata = inbox;
            RS_CTRL:     rdata = {{(DATA_W-STAT_W){1'b0}}, mask_en, overrun, pending};
            RS_MYPOLL:   rdata = my_poll;
            RS_PEERPOLL: rdata = peer_poll;
            RS_SEND, RS_RSV6, RS_RSV7: rdata = '0;
            default:     rdata = '0;
        endcase
    end

    // R9: only this side's own poll write moves its poll register
    a_r9_poll_own_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == RS_MYPOLL) |=> $stable(my_poll));
    // R3: the mask bit moves only on a control write
    a_r3_mask_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel == RS_CTRL) |=> $stable(mask_en));

endmodule

// File: rtl/icc_mailbox.sv
module icc_mailbox
    import icc_mbx_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [REG_AW-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    output logic              a_nmi,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [REG_AW-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq,
    output logic              b_nmi
);

    localparam int SIDES = 2;

    logic              sel_v  [SIDES];
    logic              wr_v   [SIDES];
    logic [REG_AW-1:0] addr_v [SIDES];
    logic [DATA_W-1:0] wdat_v [SIDES];
    logic [DATA_W-1:0] rdat_v [SIDES];
    logic              irq_v  [SIDES];
    logic              nmi_v  [SIDES];

    logic [DATA_W-1:0] out_word [SIDES];
    logic [DATA_W-1:0] poll     [SIDES];
    logic [DATA_W-1:0] inbox    [SIDES];
    logic              mask_en  [SIDES];
    logic              pend     [SIDES];
    logic              ovf      [SIDES];
    logic              s_irq    [SIDES];
    logic              s_nmi    [SIDES];
    logic              ack      [SIDES];
    logic              clr      [SIDES];

    assign sel_v[0]  = a_sel;
    assign wr_v[0]   = a_wr;
    assign addr_v[0] = a_addr;
    assign wdat_v[0] = a_wdata;
    assign sel_v[1]  = b_sel;
    assign wr_v[1]   = b_wr;
    assign addr_v[1] = b_addr;
    assign wdat_v[1] = b_wdata;

    assign a_rdata = rdat_v[0];
    assign a_irq   = irq_v[0];
    assign a_nmi   = nmi_v[0];
    assign b_rdata = rdat_v[1];
    assign b_irq   = irq_v[1];
    assign b_nmi   = nmi_v[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int PEER = SIDES - 1 - s;

        icc_mbx_port #(.DATA_W(DATA_W)) i_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel_v[s]),
            .wr        (wr_v[s]),
            .addr      (addr_v[s]),
            .wdata     (wdat_v[s]),
            .rdata     (rdat_v[s]),
            .inbox     (inbox[s]),
            .pending   (pend[s]),
            .overrun   (ovf[s]),
            .peer_poll (poll[PEER]),
            .out_word  (out_word[s]),
            .my_poll   (poll[s]),
            .mask_en   (mask_en[s]),
            .send_irq  (s_irq[s]),
            .send_nmi  (s_nmi[s]),
            .ack       (ack[s]),
            .clr_ovf   (clr[s])
        );

        // channel carrying words from the peer into side s
        icc_mbx_channel #(.DATA_W(DATA_W)) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .send_irq   (s_irq[PEER]),
            .send_nmi   (s_nmi[PEER]),
            .send_word  (out_word[PEER]),
            .rx_ack     (ack[s]),
            .rx_clr_ovf (clr[s]),
            .rx_mask_en (mask_en[s]),
            .inbox      (inbox[s]),
            .pending    (pend[s]),
            .overrun    (ovf[s]),
            .irq        (irq_v[s]),
            .nmi        (nmi_v[s])
        );
    end

    // R11: a side's channel state moves only through its own ack or the peer's send
    a_r11_b_chan_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_irq[0] && !s_nmi[0] && !ack[1] && !clr[1]) |=> ($stable(pend[1]) && $stable(inbox[1]) && $stable(ovf[1])));
    a_r11_a_chan_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_irq[1] && !s_nmi[1] && !ack[0] && !clr[0]) |=> ($stable(pend[0]) && $stable(inbox[0]) && $stable(ovf[0])));

endmodule

// File: tb/test_icc_mailbox.sv
`timescale 1ns/1ps
module test_icc_mailbox;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
    logic [2:0]   a_addr = 0, b_addr = 0;
    logic [W-1:0] a_wdata = 0, b_wdata = 0;
    logic [W-1:0] a_rdata, b_rdata;
    logic         a_irq, a_nmi, b_irq, b_nmi;

    icc_mailbox #(.DATA_W(W)) i_icc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq), .a_nmi(a_nmi),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_nmi(b_nmi)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_out [2];
    logic [W-1:0] m_poll[2];
    logic [W-1:0] m_inbox[2];
    bit m_pend[2], m_ovf[2], m_mask[2], m_nmi[2];

    function automatic logic [W-1:0] exp_read(int s, logic [2:0] ad);
        case (ad)
            3'd0: return m_out[s];
            3'd2: return m_inbox[s];
            3'd3: return {{(W-3){1'b0}}, m_mask[s], m_ovf[s], m_pend[s]};
            3'd4: return m_poll[s];
            3'd5: return m_poll[1-s];
            default: return '0;
        endcase
    endfunction

    function automatic bit exp_irq(int s);
        return m_pend[s] && m_mask[s];
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "a_nmi", {{(W-1){1'b0}}, a_nmi}, {{(W-1){1'b0}}, m_nmi[0]});
        chk(tag, "b_nmi", {{(W-1){1'b0}}, b_nmi}, {{(W-1){1'b0}}, m_nmi[1]});
        chk(tag, "a_irq", {{(W-1){1'b0}}, a_irq}, {{(W-1){1'b0}}, exp_irq(0)});
        chk(tag, "b_irq", {{(W-1){1'b0}}, b_irq}, {{(W-1){1'b0}}, exp_irq(1)});
        for (int ad = 0; ad < 8; ad++) begin
            a_addr = 3'(ad);
            b_addr = 3'(ad);
            #0.1;
            chk(tag, $sformatf("a_rd[%0d]", ad), a_rdata, exp_read(0, 3'(ad)));
            chk(tag, $sformatf("b_rd[%0d]", ad), b_rdata, exp_read(1, 3'(ad)));
        end
    endtask

    task automatic model_update(bit en[2], logic [2:0] ad[2], logic [W-1:0] dd[2]);
        bit o_pend[2];
        logic [W-1:0] o_out[2];
        o_pend = m_pend;
        o_out  = m_out;
        for (int r = 0; r < 2; r++) begin
            int t = 1 - r;
            bit snd = en[t] && ad[t] == 3'd1 && dd[t][1:0] != 2'b00;
            bit ak  = en[r] && ad[r] == 3'd3 && dd[r][0];
            bit cl  = en[r] && ad[r] == 3'd3 && dd[r][1];
            bit acc = snd && (!o_pend[r] || ak);
            if (acc) begin
                m_inbox[r] = o_out[t];
                m_pend[r]  = 1;
            end else if (ak) m_pend[r] = 0;
            if (snd && !acc) m_ovf[r] = 1;
            else if (cl)     m_ovf[r] = 0;
            m_nmi[r] = acc && dd[t][1];
        end
        for (int s = 0; s < 2; s++) begin
            if (en[s] && ad[s] == 3'd0) m_out[s]  = dd[s];
            if (en[s] && ad[s] == 3'd4) m_poll[s] = dd[s];
            if (en[s] && ad[s] == 3'd3) m_mask[s] = dd[s][2];
        end
    endtask

    task automatic step(string tag, bit e0, logic [2:0] ad0, logic [W-1:0] d0,
                        bit e1, logic [2:0] ad1, logic [W-1:0] d1);
        bit en[2];
        logic [2:0] ad[2];
        logic [W-1:0] dd[2];
        en[0] = e0; ad[0] = ad0; dd[0] = d0;
        en[1] = e1; ad[1] = ad1; dd[1] = d1;
        a_sel = e0; a_wr = e0; a_addr = ad0; a_wdata = d0;
        b_sel = e1; b_wr = e1; b_addr = ad1; b_wdata = d1;
        @(posedge clk);
        model_update(en, ad, dd);
        @(negedge clk);
        a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int s = 0; s < 2; s++) begin
            m_out[s] = 0; m_poll[s] = 0; m_inbox[s] = 0;
            m_pend[s] = 0; m_ovf[s] = 0; m_mask[s] = 0; m_nmi[s] = 0;
        end
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        step("R2", 1, 3'd0, 24'h123456, 0, 3'd0, 0);
        step("R2", 1, 3'd1, 24'h000001, 0, 3'd0, 0);
        step("R3", 0, 3'd0, 0, 1, 3'd3, 24'h000004);
        step("R5", 0, 3'd0, 0, 1, 3'd3, 24'h000005);
        step("R2", 1, 3'd0, 24'hABCDEF, 0, 3'd0, 0);
        step("R4", 1, 3'd1, 24'h000002, 0, 3'd0, 0);
        step("R4", 0, 3'd0, 0, 0, 3'd0, 0);
        step("R5", 0, 3'd0, 0, 1, 3'd3, 24'h000001);
        step("R4", 1, 3'd1, 24'h000002, 0, 3'd0, 0);
        step("R6", 1, 3'd0, 24'h111111, 0, 3'd0, 0);
        step("R6", 1, 3'd1, 24'h000003, 0, 3'd0, 0);
        step("R7", 0, 3'd0, 0, 0, 3'd0, 0);
        step("R7", 0, 3'd0, 0, 1, 3'd3, 24'h000000);
        step("R7", 0, 3'd0, 0, 1, 3'd3, 24'h000002);
        step("R8", 1, 3'd1, 24'h000001, 1, 3'd3, 24'h000001);
        step("R10", 1, 3'd1, 24'hFFFFFC, 0, 3'd0, 0);
        step("R9", 1, 3'd4, 24'hA5A5A5, 1, 3'd4, 24'h5A5A5A);
        step("R9", 1, 3'd2, 24'h777777, 1, 3'd5, 24'h666666);
        step("R9", 1, 3'd5, 24'h222222, 1, 3'd2, 24'h333333);
        step("R11", 0, 3'd0, 0, 1, 3'd0, 24'h0BEEF0);
        step("R11", 0, 3'd0, 0, 1, 3'd1, 24'h000003);
        step("R11", 0, 3'd0, 0, 0, 3'd0, 0);

        seed = $urandom(32'h1CC5EED);
        for (int i = 0; i < 600; i++) begin
            bit e0 = ($urandom % 4) != 0;
            bit e1 = ($urandom % 3) == 0;
            logic [2:0] ad0 = 3'($urandom % 8);
            logic [2:0] ad1 = 3'($urandom % 8);
            logic [W-1:0] d0 = W'($urandom);
            logic [W-1:0] d1 = W'($urandom);
            step("R11", e0, ad0, d0, e1, ad1, d1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule